// File: doc/BRIEF.md
# Selectable Small-Ratio Clock Divider

This block produces a slower clock from a fast reference clock using only ordinary flip-flops and gates, with no dedicated clock-management resource. A three-bit select input picks one of five division ratios: 2, 3, 4, 6 or 8. The select is meant to be set statically, normally while reset is held, and then left alone.

Each ratio has its own small structure. The even powers of two come from a chain of toggle flops, each clocked by the one before it. Divide-by-6 is a three-bit twisted-ring counter. Divide-by-3 keeps a 50% duty cycle by working on both clock edges. It takes a registered decode of a modulo-3 counter, delays a copy of it by half an input cycle in a falling-edge flop, and ORs the two together.

All flops clear asynchronously while reset is high, which holds the output low. Every structure then leaves reset in a known phase, so the first output rising edge lands on the first rising input edge after reset is released.

Top module: `clkdiv_sel`

## Requirements
- R1: While `rst_i` is high, `clk_o` is low.
- R2: Select code 0 gives an output period of 2 input periods, high for exactly 1 input period.
- R3: Select code 1 gives an output period of 3 input periods, high for exactly 1.5 input periods. The half-period step comes from a flop clocked on the falling input edge.
- R4: Select code 2 gives an output period of 4 input periods, high for exactly 2.
- R5: Select code 3 gives an output period of 6 input periods, high for exactly 3.
- R6: Select code 4 gives an output period of 8 input periods, high for exactly 4.
- R7: Select codes 5, 6 and 7 behave as code 0: period 2, high for 1.
- R8: After `rst_i` falls, for every select code, the first rising edge of `clk_o` follows the first rising edge of `clk_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock |
| rst_i | input | 1 | Asynchronous reset, active high; clears all stages |
| ratio_i | input | 3 | Ratio select: 0=÷2, 1=÷3, 2=÷4, 3=÷6, 4=÷8, 5..7=÷2 |
| clk_o | output | 1 | Divided clock |

## Verification
Every one of the eight select codes is applied in a fixed sweep. Further codes are then drawn at random from a fixed seed, so the block also sees sequences where a new code follows a different previous ratio across a reset.

For each code the bench times the rising and falling output edges, and compares the measured period and high time against the expected ratio. The high-time check is what separates a correct both-edge divide-by-3 from a single-edge version, which would show a 1- or 2-cycle high time. Checking the unused codes separately catches a select decode that falls through to some other ratio.

During reset the output is sampled several times. After release, the output is checked just after the first input rising edge, which shows whether each structure leaves reset in the intended phase.

// File: rtl/clkdiv_sel.sv
module clkdiv_sel #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [SEL_W-1:0] ratio_i,
  output logic             clk_o
);

  localparam logic [SEL_W-1:0] SEL_D3 = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_D4 = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_D6 = SEL_W'(3);
  localparam logic [SEL_W-1:0] SEL_D8 = SEL_W'(4);

  logic       tg0, tg1, tg2;
  logic [1:0] cnt3;
  logic       pos3, neg3;
  logic [2:0] ring6;
  logic       div3_o;

  always_ff @(posedge clk_i or posedge rst_i)
    if (rst_i) tg0 <= 1'b0;
    else       tg0 <= ~tg0;

  always_ff @(posedge tg0 or posedge rst_i)
    if (rst_i) tg1 <= 1'b0;
    else       tg1 <= ~tg1;

  always_ff @(posedge tg1 or posedge rst_i)
    if (rst_i) tg2 <= 1'b0;
    else       tg2 <= ~tg2;

  always_ff @(posedge clk_i or posedge rst_i)
    if (rst_i) begin
      cnt3 <= 2'd0;
      pos3 <= 1'b0;
    end else begin
      cnt3 <= (cnt3 == 2'd2) ? 2'd0 : cnt3 + 2'd1;
      pos3 <= (cnt3 == 2'd0);
    end

  always_ff @(negedge clk_i or posedge rst_i)
    if (rst_i) neg3 <= 1'b0;
    else       neg3 <= pos3;

  assign div3_o = pos3 | neg3;

  always_ff @(posedge clk_i or posedge rst_i)
    if (rst_i) ring6 <= 3'b000;
    else       ring6 <= {ring6[1:0], ~ring6[2]};

  always_comb begin
    case (ratio_i)
      SEL_D3:  clk_o = div3_o;
      SEL_D4:  clk_o = tg1;
      SEL_D6:  clk_o = ring6[0];
      SEL_D8:  clk_o = tg2;
      default: clk_o = tg0;
    endcase
  end

  AST_RST_OUT_LOW: assert property (@(posedge clk_i) rst_i && $past(rst_i) |-> !clk_o) // R1
    else $error("output high during reset");
  AST_DIV2_TOGGLE: assert property (@(posedge clk_i) disable iff (rst_i) tg0 |=> !tg0) // R2
    else $error("first toggle stage missed a toggle");
  AST_MOD3_WRAP: assert property (@(posedge clk_i) disable iff (rst_i) cnt3 == 2'd2 |=> cnt3 == 2'd0) // R3
    else $error("mod-3 counter did not wrap");
  AST_MOD3_RANGE: assert property (@(posedge clk_i) disable iff (rst_i) cnt3 != 2'd3) // R3
    else $error("mod-3 counter out of range");
  AST_DIV3_ONEHOT_POS: assert property (@(posedge clk_i) disable iff (rst_i) pos3 |=> !pos3) // R3
    else $error("div3 rising-edge pulse wider than one cycle");
  AST_RING_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i) ring6 != 3'b010 && ring6 != 3'b101) // R5
    else $error("twisted ring in illegal state");

endmodule

// File: tb/clkdiv_sel_tb_top.sv
`timescale 1ns/1ps
module clkdiv_sel_tb_top;
  localparam real TCLK = 8.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] ratio = 3'd0;
  logic       clk_o;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  clkdiv_sel dut_i (.clk_i(clk), .rst_i(rst), .ratio_i(ratio), .clk_o(clk_o));

  always #(TCLK/2) clk = ~clk;

  function automatic int exp_div(input logic [2:0] code);
    case (code)
      3'd1: return 3;
      3'd2: return 4;
      3'd3: return 6;
      3'd4: return 8;
      default: return 2;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] code);
    case (code)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_real(input string req, input string what, input real act, input real exp);
    n_run++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic run_code(input logic [2:0] code);
    real t_r, t_f, t_r2;
    int  d;
    d = exp_div(code);
    @(negedge clk);
    rst = 1'b1;
    ratio = code;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_bit("R1", "clk_o during reset", clk_o, 1'b0);
    end
    rst = 1'b0;
    @(posedge clk);
    #1;
    check_bit("R8", "clk_o after first edge", clk_o, 1'b1);
    for (int k = 0; k < 2; k++) begin
      @(posedge clk_o); t_r = $realtime;
      @(negedge clk_o); t_f = $realtime;
      @(posedge clk_o); t_r2 = $realtime;
      check_real(req_of(code), "period", (t_r2 - t_r) / TCLK, real'(d));
      check_real(req_of(code), "high time", (t_f - t_r) / TCLK, real'(d) / 2.0);
    end
  endtask

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (2) @(negedge clk);
    for (int c = 0; c < 8; c++) run_code(3'(c));
    for (int r = 0; r < 8; r++) run_code(3'($urandom % 8));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(TCLK * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule